// File: doc/BRIEF.md
# Key-Guarded Flash Configuration Registers

This block is a small register file on a simple register bus. It holds the configuration words that steer a flash-interface controller: an interface-setup word and a bus-timing word. Software cannot change either word freely. It must first store a 16-bit key into a key register. That opens a write window for exactly one protected write. As soon as one protected register has been written, the window shuts again. Every protected update therefore needs its own key write.

A write with a wrong key, or one that does not cover the low halfword, closes any window that is open. A write to a protected register while the window is shut is dropped without any notice. Reads are always allowed. A reset command written to the command register returns both words to zero and closes the window. The configuration fields leave the block as individual output ports.

Register offsets are byte addresses: command 0x00, interface setup 0x04, timing 0x08, key 0x0C.

Top module: `keycfg_regs`

## Requirements
- R1: After reset the window is shut, every configuration output is zero, and all four offsets read 0.
- R2: A write to offset 0x0C opens the window when bus_be[1:0] is 2'b11 and bus_wdata[15:0] is 0xA25E. While the window is open, offset 0x0C reads 1.
- R3: Any other write to offset 0x0C shuts the window: either a different low halfword, or bus_be[1:0] not equal to 2'b11.
- R4: A write to offset 0x04 or 0x08 while the window is shut leaves the register and its outputs unchanged.
- R5: With the window open, a write to 0x04 or 0x08 updates each byte whose enable is set. The window shuts in the same cycle, so a second protected write without a new key is discarded.
- R6: The interface-setup word at 0x04 holds four bits. Bit 3 is write protection (wprot_en), bit 2 is large pages (large_page), bit 1 is 5-byte addressing (addr_5byte), and bit 0 is a 16-bit bus (bus_16bit). Bits 31:4 read 0.
- R7: The timing word at 0x08 has these fields: [25:24] ce_delay, [23:19] busy_delay, [18:16] turnaround, [15:12] rd_high, [11:8] rd_low, [7:4] wr_high, [3:0] wr_low. Bits 31:26 read 0.
- R8: A write to 0x00 with bus_be[0] set and bus_wdata[7:0] = 0xFF clears both words and shuts the window. Any other command value has no effect. Offset 0x00 reads 0.
- R9: Reads are combinational from bus_addr. They are allowed whether the window is open or shut, and they never change the state of the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr |
| wprot_en | output | 1 | Write-protect enable |
| large_page | output | 1 | Large-block page select |
| addr_5byte | output | 1 | Long address select |
| bus_16bit | output | 1 | 16-bit bus select |
| ce_delay | output | 2 | Chip-enable to access delay |
| busy_delay | output | 5 | Busy delay |
| turnaround | output | 3 | Bus turnaround |
| rd_high | output | 4 | Read strobe high time |
| rd_low | output | 4 | Read strobe low time |
| wr_high | output | 4 | Write strobe high time |
| wr_low | output | 4 | Write strobe low time |

## Verification
Directed sequences cover the edge cases one at a time:
- key, then two protected writes: only the first may land;
- a wrong key, or a key written with a single byte enable, in place of the right one;
- a key that is then cancelled by a bad key;
- a command value one off from 0xFF, compared with the real reset command.

Each sequence separates a design that consumes the window from one that leaves it open. It also separates one that checks the full key from one that checks only a part of it.

Random mixes of key writes, protected writes with partial byte enables, commands and reads run against a bench model. Those mixes show whether byte merging and relocking stay consistent over long, interleaved histories.

// File: rtl/keycfg_pkg.sv
package keycfg_pkg;
   localparam int BUS_W   = 32;
   localparam int BE_W    = BUS_W / 8;
   localparam int ADDR_W  = 6;
   localparam int IFCFG_W  = 4;
   localparam int TIMING_W = 26;
   localparam int KEY_W    = 16;
   localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA25E;
   localparam logic [7:0]       RESET_CMD  = 8'hFF;
   localparam logic [ADDR_W-1:0] OFS_CMD    = 6'h00;
   localparam logic [ADDR_W-1:0] OFS_IFCFG  = 6'h04;
   localparam logic [ADDR_W-1:0] OFS_TIMING = 6'h08;
   localparam logic [ADDR_W-1:0] OFS_KEY    = 6'h0C;

   typedef struct packed {
      logic wprot;
      logic large_pg;
      logic long_addr;
      logic wide_bus;
   } ifcfg_t;

   typedef struct packed {
      logic [1:0] ce_dly;
      logic [4:0] busy_dly;
      logic [2:0] turn;
      logic [3:0] rd_hi;
      logic [3:0] rd_lo;
      logic [3:0] wr_hi;
      logic [3:0] wr_lo;
   } timing_t;
endpackage

// File: rtl/keycfg_lock.sv
module keycfg_lock
   import keycfg_pkg::*;
#(
   parameter int KW = KEY_W,
   parameter logic [KW-1:0] KEY = UNLOCK_KEY
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          key_wr,
   input  logic [KW-1:0] key_val,
   input  logic [1:0]    key_be,
   input  logic          prot_wr,
   input  logic          cmd_reset,
   output logic          unlocked
);
   logic key_ok;
   assign key_ok = (key_be == 2'b11) && (key_val == KEY);

   initial assert (KW % 8 == 0 && KW <= BUS_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   unlocked <= 1'b0;
      else if (cmd_reset || prot_wr) unlocked <= 1'b0;
      else if (key_wr)               unlocked <= key_ok;
   end

   assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_val == KEY && key_be == 2'b11) |=> unlocked);
   assert_bad_key_shuts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && (key_val != KEY || key_be != 2'b11)) |=> !unlocked);
   assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_wr && unlocked) |=> !unlocked);
endmodule

// File: rtl/keycfg_reg.sv
module keycfg_reg
   import keycfg_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit BYTE_MERGE = 1'b1,
   localparam int LANES     = (WIDTH + 7) / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             allow,
   input  logic             clr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [LANES-1:0] be,
   output logic [WIDTH-1:0] q
);
   initial assert (WIDTH >= 1 && WIDTH <= BUS_W);

   generate
      if (BYTE_MERGE) begin : g_merge
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            localparam int LO = 8 * i;
            localparam int HI = (LO + 8 > WIDTH) ? WIDTH - 1 : LO + 7;
            logic [HI-LO:0] lane_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                      lane_q <= '0;
               else if (clr)                    lane_q <= '0;
               else if (wr && allow && be[i])   lane_q <= wdata[HI:LO];
            end
            assign q[HI:LO] = lane_q;
         end
      end else begin : g_whole
         logic [WIDTH-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     word_q <= '0;
            else if (clr)                   word_q <= '0;
            else if (wr && allow && |be)    word_q <= wdata;
         end
         assign q = word_q;
      end
   endgenerate

   assert_locked_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !allow && !clr) |=> $stable(q));
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0));
endmodule

// File: rtl/keycfg_regs.sv
module keycfg_regs
   import keycfg_pkg::*;
#(
   parameter bit BYTE_MERGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic [BE_W-1:0]   bus_be,
   input  logic              bus_we,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              wprot_en,
   output logic              large_page,
   output logic              addr_5byte,
   output logic              bus_16bit,
   output logic [1:0]        ce_delay,
   output logic [4:0]        busy_delay,
   output logic [2:0]        turnaround,
   output logic [3:0]        rd_high,
   output logic [3:0]        rd_low,
   output logic [3:0]        wr_high,
   output logic [3:0]        wr_low
);
   localparam int IF_LANES = (IFCFG_W + 7) / 8;
   localparam int TM_LANES = (TIMING_W + 7) / 8;

   logic    unlocked, key_wr, ifcfg_wr, tim_wr, cmd_reset, prot_wr;
   ifcfg_t  ifcfg_q;
   timing_t tim_q;
   logic    unused_hi;

   assign unused_hi = ^bus_wdata[BUS_W-1:TIMING_W];

   assign key_wr    = bus_we && (bus_addr == OFS_KEY);
   assign ifcfg_wr  = bus_we && (bus_addr == OFS_IFCFG);
   assign tim_wr    = bus_we && (bus_addr == OFS_TIMING);
   assign cmd_reset = bus_we && (bus_addr == OFS_CMD) && bus_be[0]
                      && (bus_wdata[7:0] == RESET_CMD);
   assign prot_wr   = ifcfg_wr || tim_wr;

   keycfg_lock u_lock (
      .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
      .key_val(bus_wdata[KEY_W-1:0]), .key_be(bus_be[1:0]),
      .prot_wr(prot_wr), .cmd_reset(cmd_reset), .unlocked(unlocked)
   );

   keycfg_reg #(.WIDTH(IFCFG_W), .BYTE_MERGE(BYTE_MERGE)) u_ifcfg (
      .clk(clk), .rst_n(rst_n), .wr(ifcfg_wr), .allow(unlocked),
      .clr(cmd_reset), .wdata(bus_wdata[IFCFG_W-1:0]),
      .be(bus_be[IF_LANES-1:0]), .q(ifcfg_q)
   );

   keycfg_reg #(.WIDTH(TIMING_W), .BYTE_MERGE(BYTE_MERGE)) u_timing (
      .clk(clk), .rst_n(rst_n), .wr(tim_wr), .allow(unlocked),
      .clr(cmd_reset), .wdata(bus_wdata[TIMING_W-1:0]),
      .be(bus_be[TM_LANES-1:0]), .q(tim_q)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_IFCFG:  bus_rdata[IFCFG_W-1:0]  = ifcfg_q;
         OFS_TIMING: bus_rdata[TIMING_W-1:0] = tim_q;
         OFS_KEY:    bus_rdata[0]            = unlocked;
         default:    bus_rdata = '0;
      endcase
   end

   assign wprot_en   = ifcfg_q.wprot;
   assign large_page = ifcfg_q.large_pg;
   assign addr_5byte = ifcfg_q.long_addr;
   assign bus_16bit  = ifcfg_q.wide_bus;
   assign ce_delay   = tim_q.ce_dly;
   assign busy_delay = tim_q.busy_dly;
   assign turnaround = tim_q.turn;
   assign rd_high    = tim_q.rd_hi;
   assign rd_low     = tim_q.rd_lo;
   assign wr_high    = tim_q.wr_hi;
   assign wr_low     = tim_q.wr_lo;

   assert_open_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && ifcfg_wr && bus_be[0]) |=> (ifcfg_q == $past(bus_wdata[IFCFG_W-1:0])));
   assert_locked_timing_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && tim_wr && !cmd_reset) |=> $stable(tim_q));
   assert_cmd_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |=> (!unlocked && ifcfg_q == '0 && tim_q == '0));
endmodule

// File: tb/tb_keycfg_regs.sv
`timescale 1ns/1ps
module tb_keycfg_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_be = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic        wprot_en, large_page, addr_5byte, bus_16bit;
   logic [1:0]  ce_delay;
   logic [4:0]  busy_delay;
   logic [2:0]  turnaround;
   logic [3:0]  rd_high, rd_low, wr_high, wr_low;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [3:0]  m_if;
   logic [25:0] m_tim;
   logic        m_open;

   always #5 clk = ~clk;

   keycfg_regs dut (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      bus_addr = 6'h00; #1; chk({tag, " cmd-read R8"}, bus_rdata, 32'h0);
      bus_addr = 6'h04; #1; chk({tag, " ifcfg-read R6"}, bus_rdata, {28'h0, m_if});
      bus_addr = 6'h08; #1; chk({tag, " timing-read R7"}, bus_rdata, {6'h0, m_tim});
      bus_addr = 6'h0C; #1; chk({tag, " key-read R2"}, bus_rdata, {31'h0, m_open});
      chk({tag, " ifcfg-pins R6"}, {28'h0, wprot_en, large_page, addr_5byte, bus_16bit},
          {28'h0, m_if});
      chk({tag, " timing-pins R7"}, {6'h0, ce_delay, busy_delay, turnaround, rd_high,
          rd_low, wr_high, wr_low}, {6'h0, m_tim});
   endtask

   task automatic model(logic [5:0] a, logic [31:0] d, logic [3:0] b);
      case (a)
         6'h0C: m_open = (b[1:0] == 2'b11) && (d[15:0] == 16'hA25E);
         6'h04: if (m_open) begin
                   if (b[0]) m_if = d[3:0];
                   m_open = 1'b0;
                end
         6'h08: if (m_open) begin
                   for (int k = 0; k < 4; k++)
                      if (b[k])
                         for (int j = 0; j < 8; j++)
                            if (8*k + j < 26) m_tim[8*k+j] = d[8*k+j];
                   m_open = 1'b0;
                end
         6'h00: if (b[0] && d[7:0] == 8'hFF) begin
                   m_if = '0; m_tim = '0; m_open = 1'b0;
                end
         default: ;
      endcase
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d, logic [3:0] b);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_be = b; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      model(a, d, b);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      m_if = '0; m_tim = '0; m_open = 1'b0;
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after release");

      // R4: locked writes dropped
      wr(6'h04, 32'hF, 4'hF);
      wr(6'h08, 32'h3FF_FFFF, 4'hF);
      check_all("R4 locked");

      // R2 / R5: one-shot window
      wr(6'h0C, 32'h0000_A25E, 4'b0011);
      check_all("R2 open");
      wr(6'h04, 32'hA, 4'h1);
      check_all("R5 first write");
      wr(6'h04, 32'h5, 4'h1);
      check_all("R5 second dropped");

      // R3: wrong value, and missing byte enable
      wr(6'h0C, 32'h0000_A25F, 4'b0011);
      check_all("R3 wrong key");
      wr(6'h0C, 32'h0000_A25E, 4'b0001);
      check_all("R3 half enable");
      wr(6'h0C, 32'h0000_A25E, 4'b0011);
      wr(6'h0C, 32'h0000_125E, 4'b0011);
      wr(6'h08, 32'h1234567, 4'hF);
      check_all("R3 cancel window");

      // R7: field layout through timing pins, partial byte enables
      wr(6'h0C, 32'hFFFF_A25E, 4'b1111);
      wr(6'h08, 32'h2A5_C3E1, 4'hF);
      check_all("R7 full");
      wr(6'h0C, 32'h0000_A25E, 4'b0011);
      wr(6'h08, 32'hFFFF_FFFF, 4'b0100);
      check_all("R5 byte merge");

      // R8: near-miss command, then real reset
      wr(6'h0C, 32'h0000_A25E, 4'b0011);
      wr(6'h00, 32'h0000_00FE, 4'h1);
      check_all("R8 near-miss");
      wr(6'h00, 32'h0000_00FF, 4'h1);
      check_all("R8 reset cmd");

      // R9: reads under open window do not consume it
      wr(6'h0C, 32'h0000_A25E, 4'b0011);
      check_all("R9 reads open");
      check_all("R9 reads again");

      // random mix
      void'($urandom(32'd1234));
      for (int n = 0; n < 400; n++) begin
         logic [5:0]  a;
         logic [31:0] d;
         logic [3:0]  b;
         int op;
         op = $urandom % 7;
         d  = $urandom;
         b  = ($urandom % 3 == 0) ? 4'($urandom) : 4'hF;
         case (op)
            0, 1: begin a = 6'h0C; if ($urandom % 4 != 0) d[15:0] = 16'hA25E; end
            2:    a = 6'h04;
            3:    a = 6'h08;
            4:    begin a = 6'h00; if ($urandom % 3 == 0) d[7:0] = 8'hFF; end
            5:    a = 6'h0C;
            default: a = 6'($urandom % 16) << 2;
         endcase
         if (op == 6) begin
            check_all("R9 random read");
         end else begin
            wr(a, d, b);
            check_all("R5 random");
         end
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule